// File: doc/BRIEF.md
# Raster Timing Generator with Edge-Decoded Flags

This block produces the line and frame timing for a raster video display. A horizontal dot counter and a vertical line counter, each 9 bits wide, advance on every enabled pixel-clock cycle. Comparators watch the counters for a few fixed values. Each timing signal (sync, blanking, border, colour-burst gate) is a registered flag. One comparator match sets the flag and a second match clears it. Because the flags are not range compares, a flag whose set point lies above its clear point stays active across the counter rollover. Horizontal blanking and border work this way.

Three single-dot strobes come from the same counters. One marks the point where per-line processing starts. One marks the point where that processing is re-armed. The third strobe fires whenever only the low four bits of the dot count match a fixed phase. The surrounding video logic uses the counts, flags and strobes to schedule fetch and output. All decode positions are parameters, and the defaults below give the standard frame.

Top module: `raster_timing_gen`

## Requirements
- R1: With `pixEn` high, `hCount` steps by one per clock. In the clock after a dot where `hCount` is 452, it returns to 0, so a line lasts 453 enabled dots.
- R2: Every flag updates on the clock edge of an enabled dot, using the counts of that dot. `hSync` is set by the dot with `hCount` 0 and cleared by the dot with `hCount` 66.
- R3: `hBlank` is set at `hCount` 440 and cleared at 68. It therefore stays high through the line rollover.
- R4: `hBorder` is set at `hCount` 413 and cleared at 93.
- R5: `burstGate` is set at `hCount` 38 and cleared at 56.
- R6: `lineStrobe` is high during any enabled dot with `hCount` 412, and `reprocStrobe` during any enabled dot with `hCount` 418. Both are combinational and last one dot.
- R7: `tickStrobe` is high during any enabled dot whose `hCount[3:0]` equals 4'b1011.
- R8: `vCount` changes only on the enabled dot with `hCount` 452. On that dot it steps by one, or returns to 0 if it is 262.
- R9: The vertical flags are decoded only on the enabled dot with `hCount` 452. `vSync` is set at line 0 and cleared at line 3. `vBlank` is set at line 258 and cleared at line 16.
- R10: A clock with `rst` high puts both counts at 0, sets `hSync` and `vSync`, and clears `hBlank`, `hBorder`, `burstGate` and `vBlank`. This happens whatever the value of `pixEn`, and all strobes stay low while `rst` is high.
- R11: While `pixEn` is low, the counts and flags hold their values and all strobes are low.
- R12: If the set match and the clear match for one flag fall on the same dot, the flag becomes set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Dot enable; the block advances only when high |
| hCount | output | 9 | Horizontal dot count |
| vCount | output | 9 | Vertical line count |
| hSync | output | 1 | Horizontal sync flag |
| hBlank | output | 1 | Horizontal blanking flag |
| hBorder | output | 1 | Horizontal border flag |
| burstGate | output | 1 | Colour-burst gate flag |
| vSync | output | 1 | Vertical sync flag |
| vBlank | output | 1 | Vertical blanking flag |
| lineStrobe | output | 1 | One-dot strobe that starts line processing |
| reprocStrobe | output | 1 | One-dot strobe that re-arms line processing |
| tickStrobe | output | 1 | Strobe on every dot whose low count bits match the phase |

## Verification
The properties assume that `rst` is held for at least one clock before operation starts. They also assume that `hCount` never lies above the wrap value when counting, and only reset can guarantee this. The bench holds `rst` with `pixEn` low at start, and it asserts `rst` again only in whole-clock pulses. `pixEn` is drawn from a seeded random source in some phases and held high for a full frame in another. Holding it high ensures that the vertical wrap and every vertical decode are reached within the run.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int NUM_FLAGS   = 6;
  localparam int IDX_HSYNC   = 0;
  localparam int IDX_HBLANK  = 1;
  localparam int IDX_HBORDER = 2;
  localparam int IDX_BURST   = 3;
  localparam int IDX_VSYNC   = 4;
  localparam int IDX_VBLANK  = 5;
  // Flags with index >= FIRST_VERT decode on the vertical count
  localparam int FIRST_VERT  = IDX_VSYNC;
  // Value each flag takes in reset: both sync flags set, rest clear
  localparam logic [NUM_FLAGS-1:0] FLAG_RESET = 6'b010001;

  // Strobes from the decode (control) side to the datapath
  typedef struct packed {
    logic                 hWrap;
    logic                 vWrap;
    logic [NUM_FLAGS-1:0] setHit;
    logic [NUM_FLAGS-1:0] clrHit;
    logic                 lineHit;
    logic                 reprocHit;
    logic                 tickHit;
  } decodeT;
endpackage

// File: rtl/rtg_decode.sv
module rtg_decode import raster_pkg::*; #(
  parameter int H_BITS     = 9,
  parameter int V_BITS     = 9,
  parameter int H_WRAP     = 452,
  parameter int V_WRAP     = 262,
  parameter int HS_SET     = 0,
  parameter int HS_CLR     = 66,
  parameter int HB_SET     = 440,
  parameter int HB_CLR     = 68,
  parameter int HD_SET     = 413,
  parameter int HD_CLR     = 93,
  parameter int BU_SET     = 38,
  parameter int BU_CLR     = 56,
  parameter int VS_SET     = 0,
  parameter int VS_CLR     = 3,
  parameter int VB_SET     = 258,
  parameter int VB_CLR     = 16,
  parameter int LINE_POS   = 412,
  parameter int REPROC_POS = 418,
  parameter int TICK_BITS  = 4,
  parameter int TICK_PHASE = 11
) (
  input  logic [H_BITS-1:0] hCount,
  input  logic [V_BITS-1:0] vCount,
  output decodeT            dec
);
  localparam int SET_POS [NUM_FLAGS] = '{HS_SET, HB_SET, HD_SET, BU_SET, VS_SET, VB_SET};
  localparam int CLR_POS [NUM_FLAGS] = '{HS_CLR, HB_CLR, HD_CLR, BU_CLR, VS_CLR, VB_CLR};

  logic                 hWrapHit;
  logic [NUM_FLAGS-1:0] setVec;
  logic [NUM_FLAGS-1:0] clrVec;

  assign hWrapHit = (hCount == H_BITS'(H_WRAP));

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlagDec
    if (g >= FIRST_VERT) begin : gVert
      // vertical decodes only count on the last dot of a line
      assign setVec[g] = hWrapHit && (vCount == V_BITS'(SET_POS[g]));
      assign clrVec[g] = hWrapHit && (vCount == V_BITS'(CLR_POS[g]));
    end else begin : gHorz
      assign setVec[g] = (hCount == H_BITS'(SET_POS[g]));
      assign clrVec[g] = (hCount == H_BITS'(CLR_POS[g]));
    end
  end

  always_comb begin
    dec.hWrap     = hWrapHit;
    dec.vWrap     = (vCount == V_BITS'(V_WRAP));
    dec.setHit    = setVec;
    dec.clrHit    = clrVec;
    dec.lineHit   = (hCount == H_BITS'(LINE_POS));
    dec.reprocHit = (hCount == H_BITS'(REPROC_POS));
    dec.tickHit   = (hCount[TICK_BITS-1:0] == TICK_BITS'(TICK_PHASE));
  end
endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath import raster_pkg::*; #(
  parameter int H_BITS = 9,
  parameter int V_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pixEn,
  input  decodeT               dec,
  output logic [H_BITS-1:0]    hCount,
  output logic [V_BITS-1:0]    vCount,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 lineStrobe,
  output logic                 reprocStrobe,
  output logic                 tickStrobe
);
  logic stepOk;
  assign stepOk = pixEn && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
    end else if (pixEn) begin
      if (dec.hWrap) begin
        hCount <= '0;
        vCount <= dec.vWrap ? '0 : vCount + 1'b1;
      end else begin
        hCount <= hCount + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (rst)                 flags[g] <= FLAG_RESET[g];
      else if (pixEn) begin
        if (dec.setHit[g])      flags[g] <= 1'b1;  // set wins a tie
        else if (dec.clrHit[g]) flags[g] <= 1'b0;
      end
    end
  end

  assign lineStrobe   = stepOk && dec.lineHit;
  assign reprocStrobe = stepOk && dec.reprocHit;
  assign tickStrobe   = stepOk && dec.tickHit;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen import raster_pkg::*; #(
  parameter int H_BITS     = 9,
  parameter int V_BITS     = 9,
  parameter int H_WRAP     = 452,
  parameter int V_WRAP     = 262,
  parameter int HS_SET     = 0,
  parameter int HS_CLR     = 66,
  parameter int HB_SET     = 440,
  parameter int HB_CLR     = 68,
  parameter int HD_SET     = 413,
  parameter int HD_CLR     = 93,
  parameter int BU_SET     = 38,
  parameter int BU_CLR     = 56,
  parameter int VS_SET     = 0,
  parameter int VS_CLR     = 3,
  parameter int VB_SET     = 258,
  parameter int VB_CLR     = 16,
  parameter int LINE_POS   = 412,
  parameter int REPROC_POS = 418,
  parameter int TICK_BITS  = 4,
  parameter int TICK_PHASE = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pixEn,
  output logic [H_BITS-1:0] hCount,
  output logic [V_BITS-1:0] vCount,
  output logic              hSync,
  output logic              hBlank,
  output logic              hBorder,
  output logic              burstGate,
  output logic              vSync,
  output logic              vBlank,
  output logic              lineStrobe,
  output logic              reprocStrobe,
  output logic              tickStrobe
);
  decodeT               dec;
  logic [NUM_FLAGS-1:0] flags;

  rtg_decode #(
    .H_BITS(H_BITS), .V_BITS(V_BITS), .H_WRAP(H_WRAP), .V_WRAP(V_WRAP),
    .HS_SET(HS_SET), .HS_CLR(HS_CLR), .HB_SET(HB_SET), .HB_CLR(HB_CLR),
    .HD_SET(HD_SET), .HD_CLR(HD_CLR), .BU_SET(BU_SET), .BU_CLR(BU_CLR),
    .VS_SET(VS_SET), .VS_CLR(VS_CLR), .VB_SET(VB_SET), .VB_CLR(VB_CLR),
    .LINE_POS(LINE_POS), .REPROC_POS(REPROC_POS),
    .TICK_BITS(TICK_BITS), .TICK_PHASE(TICK_PHASE)
  ) uDecode (
    .hCount(hCount),
    .vCount(vCount),
    .dec   (dec)
  );

  rtg_datapath #(.H_BITS(H_BITS), .V_BITS(V_BITS)) uPath (
    .clk         (clk),
    .rst         (rst),
    .pixEn       (pixEn),
    .dec         (dec),
    .hCount      (hCount),
    .vCount      (vCount),
    .flags       (flags),
    .lineStrobe  (lineStrobe),
    .reprocStrobe(reprocStrobe),
    .tickStrobe  (tickStrobe)
  );

  assign hSync     = flags[IDX_HSYNC];
  assign hBlank    = flags[IDX_HBLANK];
  assign hBorder   = flags[IDX_HBORDER];
  assign burstGate = flags[IDX_BURST];
  assign vSync     = flags[IDX_VSYNC];
  assign vBlank    = flags[IDX_VBLANK];
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int H_BITS = 9,
  parameter int V_BITS = 9,
  parameter int H_WRAP = 452,
  parameter int V_WRAP = 262,
  parameter int HS_SET = 0,
  parameter int HS_CLR = 66,
  parameter int BU_SET = 38
) (
  input logic              clk,
  input logic              rst,
  input logic              pixEn,
  input logic [H_BITS-1:0] hCount,
  input logic [V_BITS-1:0] vCount,
  input logic              hSync,
  input logic              hBlank,
  input logic              hBorder,
  input logic              burstGate,
  input logic              vSync,
  input logic              vBlank,
  input logic              lineStrobe,
  input logic              tickStrobe
);
  AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pixEn && hCount == H_BITS'(H_WRAP)) |=> (hCount == '0)); // R1
  AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
    (pixEn && hCount != H_BITS'(H_WRAP)) |=> (hCount == $past(hCount) + 1'b1)); // R1
  AST_HSYNC_SET: assert property (@(posedge clk) disable iff (rst)
    (pixEn && hCount == H_BITS'(HS_SET)) |=> hSync); // R2
  AST_HSYNC_CLR: assert property (@(posedge clk) disable iff (rst)
    (pixEn && hCount == H_BITS'(HS_CLR)) |=> !hSync); // R2
  AST_BURST_SET: assert property (@(posedge clk) disable iff (rst)
    (pixEn && hCount == H_BITS'(BU_SET)) |=> burstGate); // R5
  AST_LINE_ONCE: assert property (@(posedge clk) disable iff (rst)
    lineStrobe |=> !lineStrobe); // R6
  AST_TICK_ONCE: assert property (@(posedge clk) disable iff (rst)
    tickStrobe |=> !tickStrobe); // R7
  AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(pixEn && hCount == H_BITS'(H_WRAP)) |=> $stable(vCount)); // R8
  AST_V_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pixEn && hCount == H_BITS'(H_WRAP) && vCount == V_BITS'(V_WRAP)) |=> (vCount == '0)); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> $stable({hSync, hBlank, hBorder, burstGate, vSync, vBlank})); // R11
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pixEn |-> !(lineStrobe || tickStrobe)); // R11
endmodule

bind raster_timing_gen rtg_checker #(
  .H_BITS(H_BITS), .V_BITS(V_BITS), .H_WRAP(H_WRAP), .V_WRAP(V_WRAP),
  .HS_SET(HS_SET), .HS_CLR(HS_CLR), .BU_SET(BU_SET)
) uChk (
  .clk(clk), .rst(rst), .pixEn(pixEn), .hCount(hCount), .vCount(vCount),
  .hSync(hSync), .hBlank(hBlank), .hBorder(hBorder), .burstGate(burstGate),
  .vSync(vSync), .vBlank(vBlank), .lineStrobe(lineStrobe), .tickStrobe(tickStrobe)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixEn = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [8:0] hCount, vCount, hCount1, vCount1;
  logic hSync, hBlank, hBorder, burstGate, vSync, vBlank;
  logic lineStrobe, reprocStrobe, tickStrobe;
  logic hSync1, hBlank1, hBorder1, burst1, vSync1, vBlank1, line1, reproc1, tick1;

  raster_timing_gen u0 (
    .clk(clk), .rst(rst), .pixEn(pixEn), .hCount(hCount), .vCount(vCount),
    .hSync(hSync), .hBlank(hBlank), .hBorder(hBorder), .burstGate(burstGate),
    .vSync(vSync), .vBlank(vBlank), .lineStrobe(lineStrobe),
    .reprocStrobe(reprocStrobe), .tickStrobe(tickStrobe)
  );

  // second copy with coinciding set/clear points on the burst flag (R12)
  raster_timing_gen #(.BU_SET(20), .BU_CLR(20)) u1 (
    .clk(clk), .rst(rst), .pixEn(pixEn), .hCount(hCount1), .vCount(vCount1),
    .hSync(hSync1), .hBlank(hBlank1), .hBorder(hBorder1), .burstGate(burst1),
    .vSync(vSync1), .vBlank(vBlank1), .lineStrobe(line1),
    .reprocStrobe(reproc1), .tickStrobe(tick1)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  // reference model, built from the requirements
  int mh = 0, mv = 0;
  bit mHs = 1, mHb = 0, mHd = 0, mBu = 0, mVs = 1, mVb = 0, mBu1 = 0;

  function automatic bit nextFlag(bit cur, bit setHit, bit clrHit);
    if (setHit) return 1'b1;
    if (clrHit) return 1'b0;
    return cur;
  endfunction

  function automatic bit expTick(int h, bit en, bit r);
    return en && !r && ((h % 16) == 11);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      mh <= 0; mv <= 0;
      mHs <= 1; mHb <= 0; mHd <= 0; mBu <= 0; mVs <= 1; mVb <= 0; mBu1 <= 0;
    end else if (pixEn) begin
      mHs  <= nextFlag(mHs, mh == 0,   mh == 66);
      mHb  <= nextFlag(mHb, mh == 440, mh == 68);
      mHd  <= nextFlag(mHd, mh == 413, mh == 93);
      mBu  <= nextFlag(mBu, mh == 38,  mh == 56);
      mBu1 <= nextFlag(mBu1, mh == 20, mh == 20);
      if (mh == 452) begin
        mVs <= nextFlag(mVs, mv == 0,   mv == 3);
        mVb <= nextFlag(mVb, mv == 258, mv == 16);
        mv  <= (mv == 262) ? 0 : mv + 1;
        mh  <= 0;
      end else begin
        mh <= mh + 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      if (nFails <= 20)
        $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk("R1 hCount", int'(hCount), mh);
    chk("R8 vCount", int'(vCount), mv);
    chk("R2 hSync", int'(hSync), int'(mHs));
    chk("R3 hBlank", int'(hBlank), int'(mHb));
    chk("R4 hBorder", int'(hBorder), int'(mHd));
    chk("R5 burstGate", int'(burstGate), int'(mBu));
    chk("R9 vSync", int'(vSync), int'(mVs));
    chk("R9 vBlank", int'(vBlank), int'(mVb));
    chk("R6 lineStrobe", int'(lineStrobe), int'(pixEn && !rst && mh == 412));
    chk("R6 reprocStrobe", int'(reprocStrobe), int'(pixEn && !rst && mh == 418));
    chk("R7 tickStrobe", int'(tickStrobe), int'(expTick(mh, pixEn, rst)));
    chk("R12 tie sets burst", int'(burst1), int'(mBu1));
  endtask

  task automatic checkReset();
    chk("R10 hCount", int'(hCount), 0);
    chk("R10 vCount", int'(vCount), 0);
    chk("R10 sync flags", int'({hSync, vSync}), 3);
    chk("R10 other flags", int'({hBlank, hBorder, burstGate, vBlank}), 0);
    chk("R10 strobes", int'({lineStrobe, reprocStrobe, tickStrobe}), 0);
  endtask

  task automatic runCycles(int n, int enPct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkAll();
      pixEn = (enPct >= 100) ? 1'b1 : (($urandom % 100) < enPct);
    end
  endtask

  initial begin
    int seed;
    logic [8:0] hSave, vSave;
    logic [5:0] fSave;
    seed = $urandom(32'd20231);
    // reset with enable low
    repeat (3) @(negedge clk);
    checkReset();
    rst = 1'b0;
    // random enable pattern
    runCycles(3000, 70);
    // hold check with enable low
    @(negedge clk);
    pixEn = 1'b0;
    @(negedge clk);
    hSave = hCount; vSave = vCount;
    fSave = {hSync, hBlank, hBorder, burstGate, vSync, vBlank};
    repeat (5) begin
      @(negedge clk);
      chk("R11 strobes idle", int'({lineStrobe, reprocStrobe, tickStrobe}), 0);
    end
    chk("R11 hCount held", int'(hCount), int'(hSave));
    chk("R11 vCount held", int'(vCount), int'(vSave));
    chk("R11 flags held", int'({hSync, hBlank, hBorder, burstGate, vSync, vBlank}), int'(fSave));
    // a full frame and more with enable high, reaching the vertical wrap
    runCycles(453 * 263 + 700, 100);
    // mid-run reset with enable high
    @(negedge clk);
    rst = 1'b1; pixEn = 1'b1;
    @(negedge clk);
    checkReset();
    rst = 1'b0;
    // directed: step to the first tick phase from reset
    runCycles(1000, 60);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cycles > 190000 && !done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule